// File: doc/BRIEF.md
# Pulse-Swallowing Fractional-N Divider with Decimal Residue

This block divides a fast oscillator clock by a mixed number N.F. The integer part N is a counter modulus that never changes. The fractional part F is a two-digit decimal (BCD) value between .00 and .99. The integer counter emits one output pulse every N oscillator clocks.

A reference-period strobe arrives once per reference period. On each one, the fraction is added in decimal to a residue register. Whenever that sum reaches one whole unit, an overflow is raised and only the remainder is kept. Each overflow withholds exactly one oscillator clock from the counter, so that one output interval lasts N+1 clocks. Over many reference periods the average division ratio therefore equals N.F.

The residue word is exported unchanged. It mirrors, with opposite sign, the phase-error staircase that pulse removal produces, so an external converter can cancel that error before the loop filter. The phase detector, loop filter, converter and oscillator are outside this block.

Top module: `fracn_swallow_div`

## Requirements
- R1: While reset is high, and right after reset is released, `residue_bcd` reads 8'h00 and `ovf_flag` and `div_out` are 0.
- R2: Each accumulation adds `frac_bcd` to the residue in decimal. Tenths are in bits [7:4] and hundredths in bits [3:0]. A digit sum above 9 is adjusted by adding 6 and carries into the next digit. `residue_bcd` always shows the stored residue.
- R3: When the decimal sum reaches 1.00 or more, `ovf_flag` is high for exactly one clock and the residue keeps only the fractional remainder (for example .90 + .30 leaves .20). No overflow means no `ovf_flag` pulse.
- R4: `ref_strobe` passes through a two-flop synchronizer. Each rising edge causes exactly one accumulation, however long the strobe stays high. The new residue appears after the third rising clock edge that samples the strobe high.
- R5: With no overflow pending, `div_out` is a one-clock pulse that repeats every N clocks (N at least 2).
- R6: Each overflow withholds exactly one oscillator clock from the counter, so exactly one output interval is N+1 clocks. No interval has any other length.
- R7: With N=5 and F=.30, starting from reset, ten strobes produce overflows on the 4th, 7th and 10th. This gives three stretched intervals, which is 53 oscillator clocks per ten output periods.
- R8: With F=.00 the residue stays .00, no overflow occurs and the output is a pure divide by N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| n_mod | input | 8 | Integer modulus N (at least 2) |
| frac_bcd | input | 8 | Fraction F, two BCD digits (tenths in [7:4]) |
| ref_strobe | input | 1 | Reference-period strobe, asynchronous |
| div_out | output | 1 | Divided output, one-clock pulse |
| ovf_flag | output | 1 | One-clock pulse on residue overflow |
| residue_bcd | output | 8 | Residue word for phase-error compensation |

## Verification
A wrong decimal adjust or carry shows up on `residue_bcd` as a wrong digit or a non-decimal nibble, three clocks after the strobe edge. A wrong carry out also shifts the overflow pulses to the wrong reference periods. A stuck or lost removal request shows up within one output interval, as a period of N, N+2 or some other length instead of exactly one N+1 period. The bench measures every output interval, so it can tell a missing swallow apart from a doubled one. A synchronizer that retriggers while the strobe is held high gives a doubled residue step, which is visible at the next check.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int DIGIT_W = 4;

  // Decimal add of one digit with carry; returns {carry, digit}
  function automatic logic [4:0] bcd_digit_add(input logic [3:0] a,
                                                input logic [3:0] b,
                                                input logic       cin);
    logic [4:0] raw;
    logic [4:0] adj;
    raw = {1'b0, a} + {1'b0, b} + {4'b0000, cin};
    adj = raw + 5'd6;
    if (raw > 5'd9) bcd_digit_add = {1'b1, adj[3:0]};
    else            bcd_digit_add = {1'b0, raw[3:0]};
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R4
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/bcd_accum.sv
module bcd_accum
  import fracn_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         add_en,
  input  logic [W-1:0] frac,
  output logic [W-1:0] acc_q,
  output logic         ovf_q
);
  logic [DIGITS:0] carry;
  logic [W-1:0]    sum;

  assign carry[0] = 1'b0;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [4:0] res;
    assign res = bcd_digit_add(acc_q[d*DIGIT_W +: DIGIT_W],
                               frac[d*DIGIT_W +: DIGIT_W], carry[d]);
    assign sum[d*DIGIT_W +: DIGIT_W] = res[3:0];
    assign carry[d+1] = res[4];

    // R2
    digit_decimal_chk: assert property (@(posedge clk) disable iff (rst)
      acc_q[d*DIGIT_W +: DIGIT_W] <= 4'd9);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= add_en & carry[DIGITS];
      if (add_en) acc_q <= sum;
    end
  end

  // R3
  ovf_after_add_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> $past(add_en));
  // R3
  ovf_wraps_below_frac_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (acc_q < $past(frac)));
  // R2
  residue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !add_en |=> $stable(acc_q));
endmodule

// File: rtl/swallow_counter.sv
module swallow_counter #(
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] n_mod,
  input  logic           swallow_req,
  output logic           tick_q
);
  logic           pend_q;
  logic [N_W-1:0] cnt_q;
  logic           en;

  assign en = ~pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      pend_q <= swallow_req;
      tick_q <= 1'b0;
      if (en) begin
        if (cnt_q >= n_mod - 1'b1) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R6
  swallow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> ($stable(cnt_q) && !tick_q));
  // R5
  tick_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (cnt_q == '0));
  // R5
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
endmodule

// File: rtl/fracn_swallow_div.sv
module fracn_swallow_div #(
  parameter int N_W         = 8,
  parameter int DIGITS      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int F_W = DIGITS * fracn_pkg::DIGIT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] n_mod,
  input  logic [F_W-1:0] frac_bcd,
  input  logic           ref_strobe,
  output logic           div_out,
  output logic           ovf_flag,
  output logic [F_W-1:0] residue_bcd
);
  logic add_pulse;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (ref_strobe),
    .rise(add_pulse)
  );

  bcd_accum #(.DIGITS(DIGITS)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .add_en(add_pulse),
    .frac  (frac_bcd),
    .acc_q (residue_bcd),
    .ovf_q (ovf_flag)
  );

  swallow_counter #(.N_W(N_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .n_mod      (n_mod),
    .swallow_req(ovf_flag),
    .tick_q     (div_out)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (residue_bcd == '0 && !ovf_flag && !div_out));
endmodule

// File: tb/fracn_swallow_div_tb.sv
module fracn_swallow_div_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] n_mod = 8'd5;
  logic [7:0] frac_bcd = 8'h00;
  logic       ref_strobe = 1'b0;
  logic       div_out;
  logic       ovf_flag;
  logic [7:0] residue_bcd;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fracn_swallow_div u_dut (
    .clk(clk), .rst(rst), .n_mod(n_mod), .frac_bcd(frac_bcd),
    .ref_strobe(ref_strobe), .div_out(div_out), .ovf_flag(ovf_flag),
    .residue_bcd(residue_bcd)
  );

  // {frac, expected residue, expected overflow}
  localparam logic [16:0] TBL [0:15] = '{
    {8'h30, 8'h30, 1'b0}, {8'h30, 8'h60, 1'b0}, {8'h30, 8'h90, 1'b0},
    {8'h30, 8'h20, 1'b1}, {8'h30, 8'h50, 1'b0}, {8'h30, 8'h80, 1'b0},
    {8'h30, 8'h10, 1'b1}, {8'h30, 8'h40, 1'b0}, {8'h30, 8'h70, 1'b0},
    {8'h30, 8'h00, 1'b1}, {8'h99, 8'h99, 1'b0}, {8'h99, 8'h98, 1'b1},
    {8'h99, 8'h97, 1'b1}, {8'h07, 8'h04, 1'b1}, {8'h55, 8'h59, 1'b0},
    {8'h55, 8'h14, 1'b1}
  };

  // Port monitors, sampled at the falling edge
  int cyc = 0, last_tick = 0, ovf_seen = 0;
  int n_norm = 0, n_long = 0, n_other = 0;
  bit have_last = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      ovf_seen = 0; n_norm = 0; n_long = 0; n_other = 0; have_last = 1'b0;
    end else begin
      if (ovf_flag) ovf_seen++;
      if (div_out) begin
        if (have_last) begin
          if (cyc - last_tick == int'(n_mod))          n_norm++;
          else if (cyc - last_tick == int'(n_mod) + 1) n_long++;
          else                                          n_other++;
        end
        last_tick = cyc;
        have_last = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] n, input logic [7:0] f);
    @(negedge clk);
    rst = 1'b1; n_mod = n; frac_bcd = f; ref_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobe(input int hold);
    ref_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    ref_strobe = 1'b0;
    repeat (9) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ovf_before;
    // R1 reset state, during reset
    repeat (2) @(negedge clk);
    check(residue_bcd == 8'h00 && !ovf_flag && !div_out, "R1 during reset",
          {residue_bcd, ovf_flag, div_out}, 0);
    do_reset(8'd5, 8'h30);
    check(residue_bcd == 8'h00 && !ovf_flag, "R1 after release", residue_bcd, 0);

    // Table walk: R2, R3, R7, then R6 over the whole table
    for (int i = 0; i < 16; i++) begin
      frac_bcd = TBL[i][16:9];
      ovf_before = ovf_seen;
      strobe(3);
      check(residue_bcd == TBL[i][8:1], "R2 residue", residue_bcd, TBL[i][8:1]);
      check((ovf_seen - ovf_before) == int'(TBL[i][0]), "R3 overflow",
            ovf_seen - ovf_before, TBL[i][0]);
      if (i == 9) begin
        repeat (12) @(negedge clk);
        check(n_long == 3 && ovf_seen == 3, "R7 three stretched periods", n_long, 3);
      end
    end
    repeat (20) @(negedge clk);
    check(n_long == 7, "R6 stretched interval count", n_long, 7);
    check(n_other == 0, "R6 no odd interval", n_other, 0);
    check(n_norm > 20, "R5 normal intervals", n_norm, 21);

    // R4 synchronizer latency and single accumulation on long hold
    do_reset(8'd4, 8'h25);
    ref_strobe = 1'b1;
    repeat (2) @(negedge clk);
    check(residue_bcd == 8'h00, "R4 not before third edge", residue_bcd, 0);
    @(negedge clk);
    check(residue_bcd == 8'h25, "R4 after third edge", residue_bcd, 8'h25);
    repeat (20) @(negedge clk);
    ref_strobe = 1'b0;
    repeat (9) @(negedge clk);
    check(residue_bcd == 8'h25, "R4 one add per long strobe", residue_bcd, 8'h25);
    strobe(1);
    check(residue_bcd == 8'h50, "R4 short strobe counted", residue_bcd, 8'h50);

    // R8 zero fraction, N=3
    do_reset(8'd3, 8'h00);
    for (int k = 0; k < 5; k++) strobe(2);
    repeat (10) @(negedge clk);
    check(residue_bcd == 8'h00 && ovf_seen == 0, "R8 residue zero", residue_bcd, 0);
    check(n_long == 0 && n_other == 0 && n_norm > 10, "R8 pure divide",
          n_long + n_other, 0);

    // R5 boundary N=2
    do_reset(8'd2, 8'h00);
    repeat (30) @(negedge clk);
    check(n_norm > 10 && n_other == 0 && n_long == 0, "R5 divide by two",
          n_other + n_long, 0);

    // R1 reset mid-run clears residue
    do_reset(8'd5, 8'h90);
    strobe(2);
    check(residue_bcd == 8'h90, "R2 before reset", residue_bcd, 8'h90);
    do_reset(8'd5, 8'h90);
    check(residue_bcd == 8'h00 && !ovf_flag, "R1 mid-run reset", residue_bcd, 0);
    strobe(2);
    check(residue_bcd == 8'h90 && ovf_seen == 0, "R1 restart from zero", residue_bcd, 8'h90);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule